// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads a two-level translation structure held in ordinary memory. A request carries the linear address, the frame number of the top-level directory, and a flag that allows large pages. The walker reads one directory word. If that word does not map the page by itself, the walker reads one table word. It then sets the accessed flag in each entry it used, when the flag is still clear. Finally it returns either a physical address with attributes or a fault.

The memory side is a simple word port. It has a read strobe, a write strobe, an address and write data. A single acknowledge pulse ends each transfer, and on a read that pulse also carries the data. Only one walk is in progress at a time. When a walk faults, the walker keeps the linear address in a register that software can read, and that value stays until the next fault.

Pages come in two sizes, chosen per directory entry: 4 KiB pages mapped through a table, and 4 MiB pages mapped directly by the directory entry.

Top module: `pgwalk_top`

## Requirements
- R1: The directory word is read at address {dir_frame, lin[31:22], 2'b00}. The table word is read at {directory entry bits 31:12, lin[21:12], 2'b00}.
- R2: A 4 KiB translation returns rsp_paddr = {table entry bits 31:12, lin[11:0]} with rsp_fault low.
- R3: An entry whose present bit (bit 0) is 0 ends the walk with rsp_fault high and rsp_rsvd low. No other bit of that entry has any effect.
- R4: When directory bit 7 is 1 and req_large_en was high, no table read occurs. The walk returns rsp_paddr = {directory entry bits 31:22, lin[21:0]} and rsp_large high.
- R5: A large-page directory entry with any of bits 21:12 nonzero ends the walk with rsp_fault and rsp_rsvd both high.
- R6: With req_large_en low, directory bit 7 is ignored and a table word is always fetched. Bits 21:12 are then not checked.
- R7: After a successful walk, every entry used has its accessed bit (bit 5) set in memory. A write is issued only for an entry whose bit 5 was 0, and every other bit (including ignored bits 11:9) is written back unchanged.
- R8: A walk that faults writes nothing to memory.
- R9: On a fault, fault_addr takes the full linear address of that request. A successful walk leaves fault_addr unchanged.
- R10: rsp_nocache reports bit 4 of the final entry: the table entry for 4 KiB pages, or the directory entry for 4 MiB pages.
- R11: req_ready is high only while no walk is in progress. rsp_valid is a one-cycle pulse. mem_rd and mem_wr are never high together, and each stays high with a stable address until mem_ack.
- R12: After reset, req_ready is high, and rsp_valid, mem_rd, mem_wr and fault_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_lin | input | 32 | Linear address to translate |
| req_dir_frame | input | 20 | Frame number of the directory |
| req_large_en | input | 1 | Allow 4 MiB directory mappings |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_rsvd | output | 1 | Fault cause: 1 reserved bits, 0 not present |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_nocache | output | 1 | Cache-disable bit of final entry |
| rsp_large | output | 1 | Result came from a 4 MiB mapping |
| fault_addr | output | 32 | Linear address of the last fault |
| mem_rd | output | 1 | Word read strobe |
| mem_wr | output | 1 | Word write strobe |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Transfer complete |

## Verification
A state register that drifts shows up within a single memory transfer. Symptoms include a strobe that drops before its acknowledge, both strobes high together, or req_ready high mid-walk. A wrongly held entry or large-page flag shows up at the response pulse of that same walk, as a wrong frame, offset or cache attribute. The same fault corrupts the accessed write-back, which can be seen in the memory contents as soon as the write is acknowledged. A missed or stray fault-address load shows up on fault_addr at that response and stays visible until the next fault.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int unsigned VA_W    = 32;
  localparam int unsigned PA_W    = 32;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned FRAME_W = PA_W - OFF_W;
  localparam int unsigned BIG_W   = OFF_W + IDX_W;
  localparam int unsigned BIGF_W  = PA_W - BIG_W;

  localparam int unsigned B_PRESENT  = 0;
  localparam int unsigned B_NOCACHE  = 4;
  localparam int unsigned B_ACCESSED = 5;
  localparam int unsigned B_BIG      = 7;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DIR_RD = 3'd1,
    ST_TBL_RD = 3'd2,
    ST_DIR_WR = 3'd3,
    ST_TBL_WR = 3'd4,
    ST_RESP   = 3'd5
  } walk_st_e;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr
  import pgwalk_pkg::*;
(
  input  logic [FRAME_W-1:0] dir_frame,
  input  logic [FRAME_W-1:0] tbl_frame,
  input  logic [IDX_W-1:0]   dir_idx,
  input  logic [IDX_W-1:0]   tbl_idx,
  output logic [PA_W-1:0]    dir_ea,
  output logic [PA_W-1:0]    tbl_ea
);
  localparam int unsigned PAD_W = OFF_W - IDX_W;

  always_comb begin
    dir_ea = {dir_frame, dir_idx, {PAD_W{1'b0}}};
    tbl_ea = {tbl_frame, tbl_idx, {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     mem_ack,
  input  logic     rd_present,
  input  logic     rd_big,
  input  logic     rd_acc,
  input  logic     rd_rsvd,
  input  logic     pde_acc,
  input  logic     pte_acc,
  output walk_st_e st_o,
  output logic     big_o,
  output logic     flt_o,
  output logic     rsvd_o,
  output logic     fault_hit_o
);
  walk_st_e st_q, st_d;
  logic big_q, big_d;
  logic flt_q, flt_d;
  logic rsvd_q, rsvd_d;
  logic fault_hit;
  logic info_en;

  always_comb begin
    st_d      = st_q;
    big_d     = big_q;
    flt_d     = flt_q;
    rsvd_d    = rsvd_q;
    fault_hit = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d   = ST_DIR_RD;
          big_d  = 1'b0;
          flt_d  = 1'b0;
          rsvd_d = 1'b0;
        end
      end
      ST_DIR_RD: begin
        if (mem_ack) begin
          if (!rd_present) begin
            st_d      = ST_RESP;
            flt_d     = 1'b1;
            fault_hit = 1'b1;
          end else if (rd_big) begin
            big_d = 1'b1;
            if (rd_rsvd) begin
              st_d      = ST_RESP;
              flt_d     = 1'b1;
              rsvd_d    = 1'b1;
              fault_hit = 1'b1;
            end else if (!rd_acc) begin
              st_d = ST_DIR_WR;
            end else begin
              st_d = ST_RESP;
            end
          end else begin
            st_d = ST_TBL_RD;
          end
        end
      end
      ST_TBL_RD: begin
        if (mem_ack) begin
          if (!rd_present) begin
            st_d      = ST_RESP;
            flt_d     = 1'b1;
            fault_hit = 1'b1;
          end else if (!pde_acc) begin
            st_d = ST_DIR_WR;
          end else if (!rd_acc) begin
            st_d = ST_TBL_WR;
          end else begin
            st_d = ST_RESP;
          end
        end
      end
      ST_DIR_WR: begin
        if (mem_ack) begin
          if (!big_q && !pte_acc) st_d = ST_TBL_WR;
          else                    st_d = ST_RESP;
        end
      end
      ST_TBL_WR: begin
        if (mem_ack) st_d = ST_RESP;
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign info_en = (st_q == ST_IDLE) || (st_q == ST_DIR_RD) || (st_q == ST_TBL_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      big_q  <= 1'b0;
      flt_q  <= 1'b0;
      rsvd_q <= 1'b0;
    end else if (info_en) begin
      big_q  <= big_d;
      flt_q  <= flt_d;
      rsvd_q <= rsvd_d;
    end
  end

  assign st_o        = st_q;
  assign big_o       = big_q;
  assign flt_o       = flt_q;
  assign rsvd_o      = rsvd_q;
  assign fault_hit_o = fault_hit;
endmodule

// File: rtl/pgwalk_resp.sv
module pgwalk_resp
  import pgwalk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_hit,
  input  logic [VA_W-1:0]   lin_q,
  input  logic [BIGF_W-1:0] pde_bigf,
  input  logic              pde_nc,
  input  logic [FRAME_W-1:0] pte_frame,
  input  logic              pte_nc,
  input  logic              big_q,
  input  logic              flt_q,
  input  logic              rsvd_q,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_nocache,
  output logic              rsp_large,
  output logic              rsp_rsvd,
  output logic [VA_W-1:0]   fault_addr
);
  logic [VA_W-1:0] fa_q;
  logic [PA_W-1:0] pa_small;
  logic [PA_W-1:0] pa_large;

  always_comb begin
    pa_small = {pte_frame, lin_q[OFF_W-1:0]};
    pa_large = {pde_bigf, lin_q[BIG_W-1:0]};
    if (flt_q) begin
      rsp_paddr   = '0;
      rsp_nocache = 1'b0;
      rsp_large   = 1'b0;
    end else if (big_q) begin
      rsp_paddr   = pa_large;
      rsp_nocache = pde_nc;
      rsp_large   = 1'b1;
    end else begin
      rsp_paddr   = pa_small;
      rsp_nocache = pte_nc;
      rsp_large   = 1'b0;
    end
    rsp_rsvd = flt_q & rsvd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_q <= '0;
    end else if (fault_hit) begin
      fa_q <= lin_q;
    end
  end

  assign fault_addr = fa_q;
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_lin,
  input  logic [FRAME_W-1:0] req_dir_frame,
  input  logic               req_large_en,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic               rsp_rsvd,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               rsp_nocache,
  output logic               rsp_large,
  output logic [VA_W-1:0]    fault_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [PA_W-1:0]    mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic [31:0]        mem_rdata,
  input  logic               mem_ack
);
  walk_st_e st;
  logic big_q, flt_q, rsvd_q, fault_hit;
  logic [VA_W-1:0]    lin_q;
  logic [FRAME_W-1:0] dframe_q;
  logic               le_q;
  logic [31:0]        pde_q, pte_q;
  logic accept, dir_cap, tbl_cap;
  logic rd_present, rd_big, rd_acc, rd_rsvd;
  logic [PA_W-1:0] dir_ea, tbl_ea;
  logic [31:0] acc_mask;

  assign acc_mask = 32'(1) << B_ACCESSED;

  assign accept  = req_valid && (st == ST_IDLE);
  assign dir_cap = (st == ST_DIR_RD) && mem_ack;
  assign tbl_cap = (st == ST_TBL_RD) && mem_ack;

  assign rd_present = mem_rdata[B_PRESENT];
  assign rd_big     = mem_rdata[B_BIG] & le_q;
  assign rd_acc     = mem_rdata[B_ACCESSED];
  assign rd_rsvd    = |mem_rdata[BIG_W-1:OFF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q    <= '0;
      dframe_q <= '0;
      le_q     <= 1'b0;
    end else if (accept) begin
      lin_q    <= req_lin;
      dframe_q <= req_dir_frame;
      le_q     <= req_large_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pde_q <= '0;
    end else if (dir_cap) begin
      pde_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pte_q <= '0;
    end else if (tbl_cap) begin
      pte_q <= mem_rdata;
    end
  end

  pgwalk_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .mem_ack     (mem_ack),
    .rd_present  (rd_present),
    .rd_big      (rd_big),
    .rd_acc      (rd_acc),
    .rd_rsvd     (rd_rsvd),
    .pde_acc     (pde_q[B_ACCESSED]),
    .pte_acc     (pte_q[B_ACCESSED]),
    .st_o        (st),
    .big_o       (big_q),
    .flt_o       (flt_q),
    .rsvd_o      (rsvd_q),
    .fault_hit_o (fault_hit)
  );

  pgwalk_addr u_addr (
    .dir_frame (dframe_q),
    .tbl_frame (pde_q[PA_W-1:OFF_W]),
    .dir_idx   (lin_q[VA_W-1:BIG_W]),
    .tbl_idx   (lin_q[BIG_W-1:OFF_W]),
    .dir_ea    (dir_ea),
    .tbl_ea    (tbl_ea)
  );

  pgwalk_resp u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_hit   (fault_hit),
    .lin_q       (lin_q),
    .pde_bigf    (pde_q[PA_W-1:BIG_W]),
    .pde_nc      (pde_q[B_NOCACHE]),
    .pte_frame   (pte_q[PA_W-1:OFF_W]),
    .pte_nc      (pte_q[B_NOCACHE]),
    .big_q       (big_q),
    .flt_q       (flt_q),
    .rsvd_q      (rsvd_q),
    .rsp_paddr   (rsp_paddr),
    .rsp_nocache (rsp_nocache),
    .rsp_large   (rsp_large),
    .rsp_rsvd    (rsp_rsvd),
    .fault_addr  (fault_addr)
  );

  always_comb begin
    mem_rd    = (st == ST_DIR_RD) || (st == ST_TBL_RD);
    mem_wr    = (st == ST_DIR_WR) || (st == ST_TBL_WR);
    mem_addr  = ((st == ST_TBL_RD) || (st == ST_TBL_WR)) ? tbl_ea : dir_ea;
    mem_wdata = (st == ST_TBL_WR) ? (pte_q | acc_mask) : (pde_q | acc_mask);
  end

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign rsp_fault = flt_q;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_lin,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [31:0] rsp_paddr,
  input logic        rsp_large,
  input logic [31:0] fault_addr,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack
);
  logic [31:0] seen_lin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_lin <= '0;
    else if (req_valid && req_ready) seen_lin <= req_lin;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr))); // R11
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ack) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata))); // R11
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R11
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11
  AST_WR_SETS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_wdata[5]); // R7
  AST_FAULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (fault_addr == seen_lin)); // R9
  AST_SMALL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[11:0] == seen_lin[11:0])); // R2
  AST_LARGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault && rsp_large) |-> (rsp_paddr[21:0] == seen_lin[21:0])); // R4
endmodule

bind pgwalk_top pgwalk_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_lin    (req_lin),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_paddr  (rsp_paddr),
  .rsp_large  (rsp_large),
  .fault_addr (fault_addr),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ack    (mem_ack)
);

// File: tb/pgwalk_top_tb_top.sv
`timescale 1ns/1ps
module pgwalk_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_lin;
  logic [19:0] req_dir_frame;
  logic        req_large_en;
  logic        rsp_valid, rsp_fault, rsp_rsvd, rsp_nocache, rsp_large;
  logic [31:0] rsp_paddr, fault_addr;
  logic        mem_rd, mem_wr, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  logic [31:0] mem [4096];

  pgwalk_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .req_dir_frame(req_dir_frame), .req_large_en(req_large_en),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_rsvd(rsp_rsvd),
    .rsp_paddr(rsp_paddr), .rsp_nocache(rsp_nocache), .rsp_large(rsp_large),
    .fault_addr(fault_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // memory model: one acknowledge per held strobe, data registered with it
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      for (int i = 0; i < 4096; i++) mem[i] <= '0;
      mem[1]     <= 32'h0000_1E01;
      mem[2]     <= 32'h0C00_0091;
      mem[3]     <= 32'h1000_3081;
      mem[5]     <= 32'hFFFF_FFFE;
      mem[6]     <= 32'h0000_2E01;
      mem[12'h403] <= 32'h0ABC_D011;
      mem[12'h09A] <= 32'h0055_5001;
      mem[12'hC00] <= 32'h0077_7001;
      mem[12'h800] <= 32'h1234_5000;
    end else begin
      mem_ack <= 1'b0;
      if ((mem_rd || mem_wr) && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_rd) mem_rdata <= mem[mem_addr[13:2]];
        else        mem[mem_addr[13:2]] <= mem_wdata;
      end
    end
  end

  typedef struct packed {
    logic [31:0] lin;
    logic        le;
    logic        flt;
    logic        rsvd;
    logic [31:0] pa;
    logic        nc;
    logic [1:0]  nwr;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{32'h0040_5123, 1'b1, 1'b1, 1'b0, 32'h0,         1'b0, 2'd0},
    '{32'h0040_3ABC, 1'b1, 1'b0, 1'b0, 32'h0ABC_DABC, 1'b1, 2'd2},
    '{32'h0089_ABCD, 1'b1, 1'b0, 1'b0, 32'h0C09_ABCD, 1'b1, 2'd1},
    '{32'h0089_ABCD, 1'b0, 1'b0, 1'b0, 32'h0055_5BCD, 1'b0, 2'd1},
    '{32'h00C0_0010, 1'b1, 1'b1, 1'b1, 32'h0,         1'b0, 2'd0},
    '{32'h00C0_0010, 1'b0, 1'b0, 1'b0, 32'h0077_7010, 1'b0, 2'd2},
    '{32'h0100_0000, 1'b1, 1'b1, 1'b0, 32'h0,         1'b0, 2'd0},
    '{32'h0140_0FFF, 1'b1, 1'b1, 1'b0, 32'h0,         1'b0, 2'd0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  bit busy_low;
  int nwr_seen;

  task automatic walk(input logic [31:0] lin, input bit le);
    int t;
    nwr_seen = 0;
    @(negedge clk);
    req_valid = 1'b1; req_lin = lin; req_large_en = le;
    @(negedge clk);
    req_valid = 1'b0;
    busy_low = !req_ready;
    t = 0;
    while (!rsp_valid && t < 200) begin
      if (mem_wr && mem_ack) nwr_seen++;
      @(negedge clk);
      t++;
    end
    if (t >= 200) check(1'b0, "R11 walk timeout", 32'(t), 32'd0);
  endtask

  logic [31:0] exp_fa;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_lin = '0;
    req_dir_frame = '0; req_large_en = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(req_ready == 1'b1, "R12 ready", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R12 rsp_valid", 32'(rsp_valid), 32'd0);
    check(mem_rd == 1'b0 && mem_wr == 1'b0, "R12 strobes", {mem_rd, mem_wr}, 32'd0);
    check(fault_addr == 32'h0, "R12 fault_addr", fault_addr, 32'h0);
    rst_n = 1'b1;
    exp_fa = 32'h0;

    // R8: table entry absent, directory accessed bit must stay clear
    walk(32'h0180_0000, 1'b1);
    check(rsp_fault == 1'b1 && rsp_rsvd == 1'b0, "R3 absent table", {rsp_fault, rsp_rsvd}, 32'd2);
    check(nwr_seen == 0, "R8 no writes", 32'(nwr_seen), 32'd0);
    @(negedge clk);
    check(mem[6] == 32'h0000_2E01, "R8 dir untouched", mem[6], 32'h0000_2E01);
    check(busy_low, "R11 busy during walk", 32'(busy_low), 32'd1);
    check(rsp_valid == 1'b0, "R11 rsp pulse", 32'(rsp_valid), 32'd0);
    exp_fa = 32'h0180_0000;
    check(fault_addr == exp_fa, "R9 fault_addr", fault_addr, exp_fa);

    // vector table: R1 R2 R3 R4 R5 R6 R7 R9 R10
    for (int v = 0; v < 8; v++) begin
      walk(VEC[v].lin, VEC[v].le);
      check(rsp_fault == VEC[v].flt, $sformatf("R3/R5 fault v%0d", v), 32'(rsp_fault), 32'(VEC[v].flt));
      check(nwr_seen == int'(VEC[v].nwr), $sformatf("R7/R8 writes v%0d", v), 32'(nwr_seen), 32'(VEC[v].nwr));
      if (VEC[v].flt) begin
        exp_fa = VEC[v].lin;
        check(rsp_rsvd == VEC[v].rsvd, $sformatf("R5 cause v%0d", v), 32'(rsp_rsvd), 32'(VEC[v].rsvd));
      end else begin
        check(rsp_paddr == VEC[v].pa, $sformatf("R1/R2/R4/R6 paddr v%0d", v), rsp_paddr, VEC[v].pa);
        check(rsp_nocache == VEC[v].nc, $sformatf("R10 nocache v%0d", v), 32'(rsp_nocache), 32'(VEC[v].nc));
      end
      check(fault_addr == exp_fa, $sformatf("R9 fault_addr v%0d", v), fault_addr, exp_fa);
    end

    @(negedge clk);
    // R7 write-back contents, ignored bits preserved
    check(mem[1] == 32'h0000_1E21, "R7 dir1", mem[1], 32'h0000_1E21);
    check(mem[12'h403] == 32'h0ABC_D031, "R7 tbl", mem[12'h403], 32'h0ABC_D031);
    check(mem[2] == 32'h0C00_00B1, "R7 big dir", mem[2], 32'h0C00_00B1);
    check(mem[12'h09A] == 32'h0055_5021, "R6 tbl via big dir", mem[12'h09A], 32'h0055_5021);
    check(mem[5] == 32'hFFFF_FFFE, "R3 absent untouched", mem[5], 32'hFFFF_FFFE);
    check(mem[3] == 32'h1000_30A1, "R6 dir3 acc", mem[3], 32'h1000_30A1);

    // R7 repeat: accessed already set, no write
    walk(32'h0040_3ABC, 1'b1);
    check(nwr_seen == 0, "R7 no rewrite", 32'(nwr_seen), 32'd0);
    check(rsp_paddr == 32'h0ABC_DABC, "R2 repeat paddr", rsp_paddr, 32'h0ABC_DABC);
    check(rsp_large == 1'b0, "R4 small flag", 32'(rsp_large), 32'd0);
    check(fault_addr == exp_fa, "R9 held", fault_addr, exp_fa);

    walk(32'h0089_0001, 1'b1);
    check(rsp_large == 1'b1 && rsp_paddr == 32'h0C09_0001, "R4 large again", rsp_paddr, 32'h0C09_0001);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL R11 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule